// File: doc/BRIEF.md
# PUF Challenge Sequencer and Response Packer

This block drives the comparison cycles of a ring-oscillator PUF and assembles its response. Two comparators run in parallel on each challenge. One compares oscillators at different positions inside their logic cells. The other compares oscillators at the same position in different cells. For each challenge the sequencer clears both comparators, waits one cycle, starts them, and waits until both report completion. It then captures four response bits. Two come from the slower counter of the different-position pair. The other two are the sign bit of the same-position pair and one bit of that pair's slower counter.

The captured nibbles are shifted into a 32-bit word. A full word is written to the response memory every eight challenges. A run lasts for a programmed number of challenges, and a done flag marks its end. A run-time option moves the tapped counter bits one place toward the least significant end.

Top module: `puf_seq_packer`

## Requirements
- R1: After reset, cmp_rst_o, cmp_go_o, cmp_cap_o, mem_we_o and done_o are all low, and no control strobe rises until a start strobe arrives.
- R2: A start_i pulse seen in the idle state, with no run in progress, makes cmp_rst_o high in the next cycle for exactly one cycle.
- R3: cmp_go_o goes high for one cycle, two cycles after cmp_rst_o. The cycle between them has both strobes low.
- R4: After cmp_go_o the block waits for cmp_end_i. cmp_cap_o goes high for one cycle, in the cycle after the first cycle in which cmp_end_i is sampled high. If challenges remain, cmp_rst_o follows two cycles after cmp_cap_o.
- R5: With hi_sel_i low, the captured nibble is {diff_slow_i[W-6], diff_slow_i[W-7], same_sign_i, same_slow_i[W-7]}, MSB first, where W is the counter width. Response bit k is counter bit W-k (bit 1 is the counter MSB).
- R6: With hi_sel_i high, every counter tap moves down by one: {diff_slow_i[W-7], diff_slow_i[W-8], same_sign_i, same_slow_i[W-8]}.
- R7: Nibbles enter the word at the least significant end, so the first challenge of a word ends up in bits 31:28. mem_we_o pulses for one cycle, in the cycle after the eighth capture of a word. mem_addr_o starts at 0 for each run and increases by one per write.
- R8: done_o rises in the cycle after the capture whose count equals n_chl_i (latched at start). No further comparator strobe follows, and done_o stays high until the next accepted start.
- R9: If n_chl_i is not a multiple of eight, the last partial word is written together with done_o. Its nibbles are left-aligned and the unused low bits are zero.
- R10: A start_i pulse while a run is in progress has no effect on sequencing, written data or addresses.
- R11: A start accepted after a finished run clears done_o in the next cycle and restarts the write address at 0.
- R12: last_addr_o holds the address of the most recent memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Run start strobe |
| n_chl_i | input | CHL_W | Number of challenges per run (0 means 2^CHL_W) |
| hi_sel_i | input | 1 | Tap option: 0 lower bits, 1 higher bits |
| cmp_end_i | input | 1 | Both comparisons have finished |
| diff_slow_i | input | CNT_W | Slower counter, different-position pair |
| same_slow_i | input | CNT_W | Slower counter, same-position pair |
| same_sign_i | input | 1 | Faster-oscillator indicator, same-position pair |
| cmp_rst_o | output | 1 | Comparator counter clear |
| cmp_go_o | output | 1 | Comparator start |
| cmp_cap_o | output | 1 | Capture strobe |
| mem_we_o | output | 1 | Response memory write enable |
| mem_addr_o | output | ADDR_W | Response memory write address |
| mem_data_o | output | 32 | Response memory write data |
| last_addr_o | output | ADDR_W | Address of most recent write |
| done_o | output | 1 | Run finished |

## Verification
The bench uses the default 16-bit counter and a 12-bit challenge count. With these values every tap position of both options lies inside the counter, and runs of 1 to 20 challenges cover full words, partial words and multi-word runs. A comparator model answers each start after a random delay of zero to four cycles. This covers the case where completion is already present when the wait state begins.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;

    // Sequencer states; order is the visiting order of one challenge
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_HOLD,
        ST_GO,
        ST_WAIT,
        ST_CAP
    } seq_state_e;

    // One challenge worth of response bits, MSB first
    typedef struct packed {
        logic diff_a;   // different-position pair, lower-numbered tap
        logic diff_b;   // different-position pair, next tap
        logic sign;     // same-position pair, faster-oscillator bit
        logic same_b;   // same-position pair, counter tap
    } nib_t;

    localparam int NIB_W     = $bits(nib_t);
    localparam int WORD_W    = 32;
    localparam int NIBS      = WORD_W / NIB_W;
    localparam int SLOT_W    = $clog2(NIBS);
    localparam int DIFF_TAP  = 6;   // numbered response bit for lower option
    localparam int SAME_TAP  = 7;

    // Counter index of numbered response bit k (k = 1 is the counter MSB)
    function automatic int tap_idx(input int cnt_w, input int k);
        return cnt_w - k;
    endfunction

endpackage

// File: rtl/puf_bit_pick.sv
module puf_bit_pick
    import puf_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             hi_sel_i,
    input  logic [CNT_W-1:0] diff_slow_i,
    input  logic [CNT_W-1:0] same_slow_i,
    input  logic             same_sign_i,
    output nib_t             nib_o
);
    localparam int D_LO = tap_idx(CNT_W, DIFF_TAP);
    localparam int S_LO = tap_idx(CNT_W, SAME_TAP);

    always_comb begin
        nib_o.sign = same_sign_i;
        if (hi_sel_i) begin
            nib_o.diff_a = diff_slow_i[D_LO-1];
            nib_o.diff_b = diff_slow_i[D_LO-2];
            nib_o.same_b = same_slow_i[S_LO-1];
        end else begin
            nib_o.diff_a = diff_slow_i[D_LO];
            nib_o.diff_b = diff_slow_i[D_LO-1];
            nib_o.same_b = same_slow_i[S_LO];
        end
    end
endmodule

// File: rtl/puf_seq_fsm.sv
module puf_seq_fsm
    import puf_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic cmp_end_i,
    input  logic last_chl_i,
    output logic clr_o,
    output logic cmp_rst_o,
    output logic cmp_go_o,
    output logic cmp_cap_o
);
    seq_state_e state_q, state_d;
    logic       run_q;

    assign clr_o = (state_q == ST_IDLE) && !run_q && start_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_q || start_i) state_d = ST_CLR;
            ST_CLR:  state_d = ST_HOLD;
            ST_HOLD: state_d = ST_GO;
            ST_GO:   state_d = ST_WAIT;
            ST_WAIT: if (cmp_end_i) state_d = ST_CAP;
            ST_CAP:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr_o)
                run_q <= 1'b1;
            else if (state_q == ST_CAP && last_chl_i)
                run_q <= 1'b0;
        end
    end

    assign cmp_rst_o = (state_q == ST_CLR);
    assign cmp_go_o  = (state_q == ST_GO);
    assign cmp_cap_o = (state_q == ST_CAP);
endmodule

// File: rtl/puf_packer.sv
module puf_packer
    import puf_seq_pkg::*;
#(
    parameter int CHL_W  = 12,
    parameter int ADDR_W = CHL_W - SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              cap_i,
    input  nib_t              nib_i,
    input  logic [CHL_W-1:0]  n_chl_i,
    output logic              last_chl_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_data_o,
    output logic [ADDR_W-1:0] last_addr_o,
    output logic              done_o
);
    logic [CHL_W-1:0]  cnt_q, cnt_nxt, nlim_q;
    logic [WORD_W-1:0] sr_q, sr_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [SLOT_W-1:0] slot;
    logic              word_full, flush;
    logic [SLOT_W+1:0] pad_sh;

    assign cnt_nxt    = cnt_q + 1'b1;
    assign last_chl_o = (cnt_nxt == nlim_q);
    assign sr_nxt     = {sr_q[WORD_W-NIB_W-1:0], nib_i};
    assign slot       = cnt_nxt[SLOT_W-1:0];
    assign word_full  = (slot == '0);
    assign flush      = word_full || last_chl_o;

    // Left-align a partial word: shift by the unused nibble count times four
    always_comb begin
        if (word_full)
            pad_sh = '0;
        else
            pad_sh = {SLOT_W'(NIBS[SLOT_W:0] - {1'b0, slot}), 2'b00};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            nlim_q      <= '0;
            sr_q        <= '0;
            addr_q      <= '0;
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_data_o  <= '0;
            last_addr_o <= '0;
            done_o      <= 1'b0;
        end else begin
            mem_we_o <= 1'b0;
            if (clr_i) begin
                cnt_q  <= '0;
                nlim_q <= n_chl_i;
                sr_q   <= '0;
                addr_q <= '0;
                done_o <= 1'b0;
            end else if (cap_i) begin
                cnt_q <= cnt_nxt;
                sr_q  <= sr_nxt;
                if (flush) begin
                    mem_we_o    <= 1'b1;
                    mem_data_o  <= sr_nxt << pad_sh;
                    mem_addr_o  <= addr_q;
                    last_addr_o <= addr_q;
                    addr_q      <= addr_q + 1'b1;
                end
                if (last_chl_o)
                    done_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/puf_seq_packer.sv
module puf_seq_packer
    import puf_seq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CHL_W  = 12,
    parameter int ADDR_W = CHL_W - SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CHL_W-1:0]  n_chl_i,
    input  logic              hi_sel_i,
    input  logic              cmp_end_i,
    input  logic [CNT_W-1:0]  diff_slow_i,
    input  logic [CNT_W-1:0]  same_slow_i,
    input  logic              same_sign_i,
    output logic              cmp_rst_o,
    output logic              cmp_go_o,
    output logic              cmp_cap_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_data_o,
    output logic [ADDR_W-1:0] last_addr_o,
    output logic              done_o
);
    nib_t nib;
    logic clr, last_chl;

    puf_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmp_end_i  (cmp_end_i),
        .last_chl_i (last_chl),
        .clr_o      (clr),
        .cmp_rst_o  (cmp_rst_o),
        .cmp_go_o   (cmp_go_o),
        .cmp_cap_o  (cmp_cap_o)
    );

    puf_bit_pick #(.CNT_W(CNT_W)) u_pick (
        .hi_sel_i    (hi_sel_i),
        .diff_slow_i (diff_slow_i),
        .same_slow_i (same_slow_i),
        .same_sign_i (same_sign_i),
        .nib_o       (nib)
    );

    puf_packer #(.CHL_W(CHL_W), .ADDR_W(ADDR_W)) u_pack (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (clr),
        .cap_i       (cmp_cap_o),
        .nib_i       (nib),
        .n_chl_i     (n_chl_i),
        .last_chl_o  (last_chl),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_data_o  (mem_data_o),
        .last_addr_o (last_addr_o),
        .done_o      (done_o)
    );
endmodule

// File: rtl/puf_seq_packer_chk.sv
module puf_seq_packer_chk (
    input logic clk,
    input logic rst,
    input logic cmp_end_i,
    input logic cmp_rst_o,
    input logic cmp_go_o,
    input logic cmp_cap_o,
    input logic mem_we_o,
    input logic done_o
);
    // R1: strobes never overlap
    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmp_rst_o, cmp_go_o, cmp_cap_o}));

    // R2: comparator clear lasts one cycle
    p_clr_single_r2: assert property (@(posedge clk) disable iff (rst)
        cmp_rst_o |=> !cmp_rst_o);

    // R3: start follows the clear after one quiet cycle
    p_go_after_clr_r3: assert property (@(posedge clk) disable iff (rst)
        cmp_rst_o |=> ##1 cmp_go_o);

    // R4: capture only after completion was sampled
    p_cap_after_end_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_cap_o) |-> $past(cmp_end_i));

    // R7: memory write only right after a capture, single cycle
    p_we_after_cap_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> ($past(cmp_cap_o) && !cmp_cap_o));

    // R8: done rises only right after a capture
    p_done_after_cap_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(cmp_cap_o));
endmodule

bind puf_seq_packer puf_seq_packer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_end_i (cmp_end_i),
    .cmp_rst_o (cmp_rst_o),
    .cmp_go_o  (cmp_go_o),
    .cmp_cap_o (cmp_cap_o),
    .mem_we_o  (mem_we_o),
    .done_o    (done_o)
);

// File: tb/puf_seq_packer_tb.sv
module puf_seq_packer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 16;
    localparam int CHW = 12;
    localparam int AW  = CHW - 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CHW-1:0] nchl = '0;
    logic          hi = 1'b0;
    logic          end_i = 1'b0;
    logic [CW-1:0] dslow = '0;
    logic [CW-1:0] sslow = '0;
    logic          sgn = 1'b0;
    logic          c_rst, c_go, c_cap, we, done;
    logic [AW-1:0] waddr, laddr;
    logic [31:0]   wdata;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    puf_seq_packer #(.CNT_W(CW), .CHL_W(CHW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .n_chl_i(nchl), .hi_sel_i(hi),
        .cmp_end_i(end_i), .diff_slow_i(dslow), .same_slow_i(sslow),
        .same_sign_i(sgn), .cmp_rst_o(c_rst), .cmp_go_o(c_go), .cmp_cap_o(c_cap),
        .mem_we_o(we), .mem_addr_o(waddr), .mem_data_o(wdata),
        .last_addr_o(laddr), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_nib(input logic [CW-1:0] d, input logic [CW-1:0] s,
                                           input logic sg, input logic h);
        int o;
        o = h ? 1 : 0;
        return {d[CW-6-o], d[CW-7-o], sg, s[CW-7-o]};
    endfunction

    task automatic run_job(input int n, input bit hm, input bit poke, input bit restart);
        int ncap = 0, nword = 0, wcnt = -1, cyc = 0, tail = 0, cap_ago = -1, m;
        bit exp_we = 0, finished = 0, poked = 0, last_end;
        logic [31:0] acc = '0, exp_data = '0;
        int exp_addr = 0;
        @(negedge clk);
        hi = hm; nchl = CHW'(n); start = 1'b1;
        last_end = end_i;
        while (!finished && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (start) begin
                start = 1'b0;
                if (poked) chk(!c_rst, "R10", "clear after mid-run start", c_rst, 0);
            end
            if (cyc == 1) begin
                chk(c_rst, "R2", "clear after start", c_rst, 1);
                if (restart) chk(!done, "R11", "done cleared", done, 0);
            end
            if (cyc == 2) chk(!c_rst && !c_go, "R3", "quiet cycle", {c_rst, c_go}, 0);
            if (cyc == 3) chk(c_go, "R3", "start strobe", c_go, 1);
            if (exp_we) begin
                chk(we, "R7", "write enable", we, 1);
                chk(wdata == exp_data, (ncap == n && n % 8 != 0) ? "R9" : "R7",
                    "write data", wdata, exp_data);
                chk(waddr == AW'(exp_addr), "R7", "write address", waddr, exp_addr);
            end else if (we) begin
                chk(0, "R7", "unexpected write", we, 0);
            end
            exp_we = 0;
            if (cap_ago >= 0) begin
                cap_ago++;
                if (cap_ago == 2) begin
                    if (ncap < n) chk(c_rst, "R4", "next clear after capture", c_rst, 1);
                    cap_ago = -1;
                end
            end
            if (ncap == n) begin
                tail++;
                chk(done, "R8", "done after last capture", done, 1);
                chk(!c_rst && !c_go && !c_cap, "R8", "no strobe after done",
                    {c_rst, c_go, c_cap}, 0);
                if (tail == 4) finished = 1;
            end
            if (c_rst) end_i = 1'b0;
            if (c_go) begin
                dslow = CW'($urandom);
                sslow = CW'($urandom);
                sgn   = 1'($urandom);
                wcnt  = int'($urandom % 5);
                if (poke && !poked && ncap == 2) begin
                    start = 1'b1;
                    poked = 1;
                end
            end
            if (wcnt == 0) begin
                end_i = 1'b1;
                wcnt = -1;
            end else if (wcnt > 0) begin
                wcnt--;
            end
            if (c_cap) begin
                chk(last_end, "R4", "completion before capture", last_end, 1);
                chk(!done, "R8", "done low during run", done, 0);
                acc = {acc[27:0], exp_nib(dslow, sslow, sgn, hm)};
                ncap++;
                cap_ago = 0;
                if (ncap % 8 == 0 || ncap == n) begin
                    m = ncap % 8;
                    exp_data = (m == 0) ? acc : (acc << (4 * (8 - m)));
                    exp_addr = nword;
                    nword++;
                    exp_we = 1;
                end
            end
            last_end = end_i;
        end
        if (!finished) chk(0, "R8", "watchdog expired", cyc, 0);
        chk(laddr == AW'(nword - 1), "R12", "last address", laddr, nword - 1);
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h5EED_0042));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!c_rst && !c_go && !c_cap && !we && !done, "R1", "idle outputs",
            {c_rst, c_go, c_cap, we, done}, 0);
        run_job(8, 1'b0, 1'b0, 1'b0);    // R5 R7 lower taps, one full word
        run_job(16, 1'b1, 1'b0, 1'b1);   // R6 R11 higher taps, restart after done
        run_job(11, 1'b0, 1'b1, 1'b1);   // R9 R10 partial word, ignored mid-run start
        run_job(3, 1'b1, 1'b0, 1'b1);    // R9 short partial word
        run_job(1, 1'b0, 1'b0, 1'b1);    // single challenge
        for (int i = 0; i < 4; i++)
            run_job(1 + int'($urandom % 20), 1'($urandom), 1'b0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog global timeout actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule